// File: doc/BRIEF.md
# Precision-scalable signed Booth multiplier

This block multiplies two signed operand words, a feature-map word (the multiplicand) and a weight word (the multiplier). A mode input decides whether each word is one full-width value, two half-width values or four quarter-width values. With the default 8-bit words it returns one 8x8 product, two independent 4x4 products or four independent 2x2 products. All of them come out in one packed 16-bit result word. It is meant to sit at the heart of a multiply-accumulate cell in a systolic array. The caller presents operands and mode with an input valid, and picks up the result one clock later.

Internally a single radix-4 Booth datapath is shared by every mode. The weight word is cut into 2-bit slices, and each slice drives one Booth digit. At a lane's lowest slice, the bit below the slice is forced to zero. The multiplicand is sign-extended separately for each lane. Each partial product is masked to its own lane's result field. The partial products are then summed by adders that suppress the carry at every lane-field boundary. So no partial product or carry crosses from one lane into another.

The output stage is a two-state machine. ST_EMPTY means no result is held and ST_HOLD means the result register holds a fresh product. There are three transitions:
- load: ST_EMPTY to ST_HOLD when in_valid is high.
- stay: ST_HOLD to ST_HOLD when in_valid is high.
- drain: ST_HOLD to ST_EMPTY when in_valid is low.

An idle ST_EMPTY stays where it is when in_valid is low.

Top module: `prec_booth_mul`

## Requirements
- R1: With mode 2'b00, result is the 16-bit two's complement product of the signed 8-bit mcand and mplier, presented on the clock after the operation is accepted.
- R2: With mode 2'b01, result[7:0] is the signed product of mcand[3:0] and mplier[3:0], and result[15:8] is the signed product of mcand[7:4] and mplier[7:4]. Each is an 8-bit two's complement value.
- R3: With mode 2'b10, result[4k+3:4k] is the 4-bit two's complement product of the signed slices mcand[2k+1:2k] and mplier[2k+1:2k], for k = 0 to 3.
- R4: With mode 2'b11 (reserved), the accepted operation sets result to zero.
- R5: out_valid equals in_valid of the previous clock. Mode is captured in the same cycle as the operands.
- R6: In the split modes, each lane's result field depends only on that lane's operand slices. For example, a zero multiplicand slice yields a zero field, whatever the other lanes hold.
- R7: The most negative operands multiply correctly. In mode 00, 8'h80 times 8'h80 gives 16'h4000. In mode 01, 4'h8 times 4'h8 gives 8'h40 in each half. In mode 10, 2'b10 times 2'b10 gives 4'h4 in each quarter.
- R8: During reset and until the first accepted operation, out_valid is 0 and result is 16'h0000.
- R9: In a cycle where in_valid is low, result keeps its previous value on the following clock, whatever the operands and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are accepted this cycle |
| mode | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 four lanes, 11 reserved |
| mcand | input | 8 | Multiplicand word (feature-map data), signed per lane |
| mplier | input | 8 | Multiplier word (weight), Booth-recoded per lane |
| out_valid | output | 1 | Result holds the product of the previous cycle's operands |
| result | output | 16 | Packed per-lane products |

## Verification
The bench builds the block with its default parameters: 8-bit operand words and 4-bit carry segments. That keeps the whole input space small enough to sweep. Every one of the 65536 operand pairs is applied back to back in each of the three active modes. A behavioural per-lane integer model predicts the outcome on every clock. This reaches every Booth digit pattern at every lane position, every most-negative corner, and every combination of neighbouring-lane values that could leak carries or sign bits across a boundary. Directed steps add the reserved mode, idle cycles with changing operands, and the reset state.

// File: rtl/prec_mul_pkg.sv
package prec_mul_pkg;

    localparam int OPW_DEFAULT = 8;

    typedef enum logic [1:0] {
        MODE_W8  = 2'b00,
        MODE_W4  = 2'b01,
        MODE_W2  = 2'b10,
        MODE_RSV = 2'b11
    } lane_mode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } out_state_e;

endpackage

// File: rtl/prec_booth_pp.sv
// One radix-4 Booth digit: recode the bit triple, scale the lane-extended
// multiplicand, confine it to its lane field and place it.
module prec_booth_pp #(
    parameter int RW  = 16,
    parameter int SHW = 4
) (
    input  logic [2:0]     trip,
    input  logic [RW-1:0]  mcand_x,
    input  logic [SHW-1:0] sh,
    input  logic [RW-1:0]  keep,
    input  logic [SHW-1:0] off,
    output logic [RW-1:0]  pp
);

    logic [RW-1:0] sel;
    logic [RW-1:0] placed;

    always_comb begin
        unique case (trip)
            3'b000, 3'b111: sel = '0;
            3'b001, 3'b010: sel = mcand_x;
            3'b011:         sel = mcand_x << 1;
            3'b100:         sel = ~(mcand_x << 1) + RW'(1);
            3'b101, 3'b110: sel = ~mcand_x + RW'(1);
        endcase
    end

    always_comb begin
        placed = (sel << sh) & keep;
        pp     = placed << off;
    end

endmodule

// File: rtl/prec_seg_adder.sv
// Adder split into segments; the carry into a segment is suppressed
// where kill marks a lane-field boundary.
module prec_seg_adder #(
    parameter int RW   = 16,
    parameter int SEGW = 4,
    localparam int NSEG = RW / SEGW
) (
    input  logic [RW-1:0]     a,
    input  logic [RW-1:0]     b,
    input  logic [NSEG-1:1]   kill,
    output logic [RW-1:0]     sum
);

    logic [NSEG-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        if (s < NSEG - 1) begin : g_mid
            logic [SEGW:0] w;
            assign w = {1'b0, a[s*SEGW +: SEGW]} + {1'b0, b[s*SEGW +: SEGW]}
                     + {{SEGW{1'b0}}, cy[s]};
            assign sum[s*SEGW +: SEGW] = w[SEGW-1:0];
            assign cy[s+1] = w[SEGW] & ~kill[s+1];
        end else begin : g_top
            assign sum[s*SEGW +: SEGW] = a[s*SEGW +: SEGW] + b[s*SEGW +: SEGW]
                                       + {{(SEGW-1){1'b0}}, cy[s]};
        end
    end

endmodule

// File: rtl/prec_booth_mul.sv
module prec_booth_mul
    import prec_mul_pkg::*;
#(
    parameter int OPW  = OPW_DEFAULT,
    parameter int SEGW = OPW / 2,
    localparam int RW   = 2 * OPW,
    localparam int NDIG = OPW / 2,
    localparam int NSEG = RW / SEGW,
    localparam int SHW  = $clog2(RW),
    localparam int Q    = OPW / 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      mode,
    input  logic [OPW-1:0]  mcand,
    input  logic [OPW-1:0]  mplier,
    output logic            out_valid,
    output logic [RW-1:0]   result
);

    lane_mode_e    mode_e;
    logic [RW-1:0] mcand_w;
    logic [RW-1:0] pp  [NDIG];
    logic [RW-1:0] acc [NDIG];
    logic [NSEG-1:1] kill;
    logic [RW-1:0] prod;
    out_state_e    st_q, st_d;
    logic [RW-1:0] result_q;

    assign mode_e  = lane_mode_e'(mode);
    assign mcand_w = {{OPW{1'b0}}, mcand};

    // carry suppression at lane-field boundaries
    always_comb begin
        int fw;
        unique case (mode_e)
            MODE_W4: fw = OPW;
            MODE_W2: fw = OPW / 2;
            default: fw = RW;
        endcase
        for (int s = 1; s < NSEG; s++) begin
            kill[s] = ((s * SEGW) % fw) == 0;
        end
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_dig
        logic          ybelow;
        logic          yl;
        logic [2:0]    trip;
        logic [RW-1:0] xext;
        logic [RW-1:0] xtmp;
        logic [RW-1:0] keep;
        logic [SHW-1:0] sh;
        logic [SHW-1:0] off;

        if (j == 0) begin : g_first
            assign ybelow = 1'b0;
        end else begin : g_rest
            assign ybelow = mplier[2*j-1];
        end

        always_comb begin
            int lw, dpl, k, f;
            unique case (mode_e)
                MODE_W4: lw = OPW / 2;
                MODE_W2: lw = OPW / 4;
                default: lw = OPW;
            endcase
            dpl  = lw / 2;
            k    = j / dpl;
            f    = k * dpl;
            yl   = (j == f) ? 1'b0 : ybelow;
            xtmp = mcand_w << (RW - lw * (k + 1));
            xext = RW'($signed(xtmp) >>> (RW - lw));
            keep = (RW'(1) << (2 * lw)) - RW'(1);
            sh   = SHW'(2 * (j - f));
            off  = SHW'(2 * lw * k);
        end

        assign trip = {mplier[2*j+1], mplier[2*j], yl};

        prec_booth_pp #(.RW(RW), .SHW(SHW)) u_pp (
            .trip    (trip),
            .mcand_x (xext),
            .sh      (sh),
            .keep    (keep),
            .off     (off),
            .pp      (pp[j])
        );

        if (j == 0) begin : g_acc0
            assign acc[0] = pp[0];
        end else begin : g_accn
            prec_seg_adder #(.RW(RW), .SEGW(SEGW)) u_add (
                .a    (acc[j-1]),
                .b    (pp[j]),
                .kill (kill),
                .sum  (acc[j])
            );
        end
    end

    assign prod = acc[NDIG-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // transitions: load, stay, drain
    always_comb begin
        unique case (st_q)
            ST_EMPTY: st_d = in_valid ? ST_HOLD : ST_EMPTY;
            ST_HOLD:  st_d = in_valid ? ST_HOLD : ST_EMPTY;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= (mode_e == MODE_RSV) ? '0 : prod;
        end
    end

    assign out_valid = (st_q == ST_HOLD);
    assign result    = result_q;

    localparam logic [OPW-1:0] ONES_W4 = {2{{(OPW/2-1){1'b0}}, 1'b1}};
    localparam logic [OPW-1:0] ONES_W2 = {4{{(Q-1){1'b0}}, 1'b1}};
    localparam logic [OPW-1:0] MINV    = {1'b1, {(OPW-1){1'b0}}};

    p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_unit_w8_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W8 && mplier == OPW'(1)) |=>
        result == {{OPW{$past(mcand[OPW-1])}}, $past(mcand)});
    p_unit_w4_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W4 && mplier == ONES_W4) |=>
        result == {{(OPW/2){$past(mcand[OPW-1])}}, $past(mcand[OPW-1:OPW/2]),
                   {(OPW/2){$past(mcand[OPW/2-1])}}, $past(mcand[OPW/2-1:0])});
    p_unit_w2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W2 && mplier == ONES_W2) |=>
        result == {{Q{$past(mcand[4*Q-1])}}, $past(mcand[3*Q +: Q]),
                   {Q{$past(mcand[3*Q-1])}}, $past(mcand[2*Q +: Q]),
                   {Q{$past(mcand[2*Q-1])}}, $past(mcand[Q +: Q]),
                   {Q{$past(mcand[Q-1])}},   $past(mcand[0 +: Q])});
    p_rsv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_RSV) |=> result == '0);
    p_lane_iso_w2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W2 && mcand[OPW-1 -: Q] == '0) |=>
        result[RW-1 -: 2*Q] == '0);
    p_lane_iso_w4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W4 && mcand[OPW/2-1:0] == '0) |=>
        result[OPW-1:0] == '0);
    p_minneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_W8 && mcand == MINV && mplier == MINV) |=>
        result == (RW'(1) << (RW - 2)));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

endmodule

// File: tb/tb_prec_booth_mul.sv
`timescale 1ns/1ps
module tb_prec_booth_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  mcand = 8'h00;
    logic [7:0]  mplier = 8'h00;
    logic        out_valid;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       cur_tag = "R1";
    logic        exp_v;
    logic [15:0] exp_r;
    string       exp_tag;

    always #2 clk = ~clk;

    prec_booth_mul dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .mcand(mcand), .mplier(mplier), .out_valid(out_valid), .result(result)
    );

    function automatic logic [15:0] ref_mul(input logic [1:0] m,
                                             input logic [7:0] a,
                                             input logic [7:0] b);
        logic [15:0] r;
        int va, vb, p, w, n;
        r = '0;
        unique case (m)
            2'b00: begin w = 8; n = 1; end
            2'b01: begin w = 4; n = 2; end
            2'b10: begin w = 2; n = 4; end
            default: begin w = 0; n = 0; end
        endcase
        for (int k = 0; k < n; k++) begin
            va = (int'(a) >> (w * k)) & ((1 << w) - 1);
            vb = (int'(b) >> (w * k)) & ((1 << w) - 1);
            if (va >= (1 << (w - 1))) va -= (1 << w);
            if (vb >= (1 << (w - 1))) vb -= (1 << w);
            p = va * vb;
            for (int t = 0; t < 2 * w; t++) r[2 * w * k + t] = p[t];
        end
        return r;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_v   <= 1'b0;
            exp_r   <= 16'h0000;
            exp_tag <= "R8";
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_r   <= ref_mul(mode, mcand, mplier);
                exp_tag <= cur_tag;
            end else begin
                exp_tag <= "R9";
            end
        end
    end

    task automatic compare();
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL R5: out_valid=%b expected=%b", out_valid, exp_v);
        end
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", exp_tag, result, exp_r);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] m,
                        input logic [7:0] a, input logic [7:0] b,
                        input string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        mode     = m;
        mcand    = a;
        mplier   = b;
        cur_tag  = tag;
    endtask

    initial begin
        // R8: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; mcand = 8'h7f; mplier = 8'h7f;
            checks++;
            if (out_valid !== 1'b0 || result !== 16'h0000) begin
                errors++;
                $display("FAIL R8: out_valid=%b result=%h expected=0 0000",
                         out_valid, result);
            end
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        // R7: most negative lane values
        step(1'b1, 2'b00, 8'h80, 8'h80, "R7");
        step(1'b1, 2'b01, 8'h88, 8'h88, "R7");
        step(1'b1, 2'b10, 8'haa, 8'haa, "R7");
        // R9: idle cycles with moving operands
        step(1'b0, 2'b00, 8'h5a, 8'hc3, "R9");
        step(1'b0, 2'b11, 8'h13, 8'h77, "R9");
        // R1: full sweep, one lane
        for (int i = 0; i < 65536; i++)
            step(1'b1, 2'b00, i[15:8], i[7:0], "R1");
        step(1'b0, 2'b01, 8'hff, 8'hff, "R9");
        // R2 / R6: full sweep, two lanes
        for (int i = 0; i < 65536; i++)
            step(1'b1, 2'b01, i[15:8], i[7:0], "R2 R6");
        // R3 / R6: full sweep, four lanes
        for (int i = 0; i < 65536; i++)
            step(1'b1, 2'b10, i[15:8], i[7:0], "R3 R6");
        // R4: reserved mode after a nonzero product
        step(1'b1, 2'b00, 8'h7f, 8'h7f, "R1");
        for (int i = 0; i < 64; i++)
            step(1'b1, 2'b11, 8'(i * 37 + 1), 8'(i * 11 + 3), "R4");
        step(1'b0, 2'b00, 8'h00, 8'h00, "R9");
        step(1'b0, 2'b00, 8'h00, 8'h00, "R9");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (199500) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule